// File: doc/BRIEF.md
# Pausable Thirty-Second Countdown Timer

This block counts down whole seconds from thirty to zero. A synchronous reset loads thirty and parks the timer in the paused state. A single-cycle start/stop pulse, already debounced outside the block, flips the timer between paused and running. While running, every cycle on which the one-per-second tick enable is high takes one second off the count. The count is presented as two BCD digits, tens and units.

A status LED shows whether the timer is running. When the count reaches zero it stays there and a bank of LEDs lights fully until the next reset. From then on, start/stop pulses have no effect. Clock division, debouncing and display driving are outside the block.

Top module: `pause_countdown_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next state is paused with the count at 30: `tens_digit`=3, `units_digit`=0, `run_led`=0 and `led_bank` all zeros.
- R2: On an edge where `sec_tick` is high, the timer is running and the count is not zero, the count drops by exactly one. The new value is visible right after that edge.
- R3: The count does not change on an edge where `sec_tick` is low or the timer is paused.
- R4: A `start_stop` pulse on an edge where the count is nonzero flips the run state. `run_led` is 1 while running and 0 while paused.
- R5: The count never wraps below zero. Once at zero it stays at zero until reset, whatever ticks arrive.
- R6: Every bit of `led_bank` is 1 exactly when the count is zero. Otherwise every bit is 0.
- R7: A `start_stop` pulse on an edge where the count is zero changes no output.
- R8: `tens_digit` holds the tens decimal digit (0 to 3) and `units_digit` holds the units decimal digit (0 to 9), both in binary. Stepping down from a units digit of 0 gives units 9 and lowers the tens by one.
- R9: When `start_stop` and `sec_tick` are high on the same edge, whether that tick decrements is decided by the run state before the edge.
- R10: Reset takes priority over `sec_tick` and `start_stop`, and it restores the count from any value, including zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_stop | input | 1 | Debounced single-cycle pulse that toggles run/pause |
| sec_tick | input | 1 | One-cycle enable, once per second |
| tens_digit | output | 4 | Tens digit of the remaining seconds |
| units_digit | output | 4 | Units digit of the remaining seconds |
| run_led | output | 1 | 1 while running, 0 while paused |
| led_bank | output | LED_W | All ones when the count is zero, otherwise all zeros |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:
- The digits and `run_led` are registered at the edge where `rst`, `sec_tick` or `start_stop` is sampled.
- `led_bank` follows the registered count combinationally, so it changes at that same edge.

The bench drives inputs on the falling edge. At the rising edge it advances a behavioural integer model. It then compares all four outputs on the following falling edge, every cycle. As a result each check lands exactly one edge after its stimulus, with no race at the active edge.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  typedef enum logic {
    ST_PAUSED  = 1'b0,
    ST_RUNNING = 1'b1
  } run_state_e;

  typedef struct packed {
    logic [3:0] tens;
    logic [3:0] units;
  } bcd2_t;

  // one-second decrement with borrow from units into tens
  function automatic bcd2_t bcd2_dec(bcd2_t v);
    bcd2_t r;
    if (v.units == 4'd0) begin
      r.units = 4'd9;
      r.tens  = v.tens - 4'd1;
    end else begin
      r.units = v.units - 4'd1;
      r.tens  = v.tens;
    end
    return r;
  endfunction

  function automatic int unsigned bcd2_value(bcd2_t v);
    return int'(v.tens) * 10 + int'(v.units);
  endfunction

  function automatic logic bcd2_is_zero(bcd2_t v);
    return (v.tens == 4'd0) && (v.units == 4'd0);
  endfunction

endpackage

// File: rtl/run_toggle_fsm.sv
module run_toggle_fsm
  import cdt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic toggle_i,
  input  logic freeze_i,
  output logic running_o
);

  run_state_e state_q, state_d;
  logic       flip_evt;

  assign flip_evt = toggle_i && !freeze_i;

  always_comb begin
    state_d = state_q;
    if (flip_evt) begin
      state_d = (state_q == ST_RUNNING) ? ST_PAUSED : ST_RUNNING;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_PAUSED;
    else     state_q <= state_d;
  end

  assign running_o = (state_q == ST_RUNNING);

  // R1: reset parks the FSM paused
  a_r1_reset_paused: assert property (@(posedge clk) rst |=> !running_o);

  // R4: accepted pulse flips the state
  a_r4_toggle_flips: assert property (@(posedge clk) disable iff (rst)
    (toggle_i && !freeze_i) |=> (running_o != $past(running_o)));

  // R4: without a pulse the state holds
  a_r4_hold_no_pulse: assert property (@(posedge clk) disable iff (rst)
    !toggle_i |=> $stable(running_o));

  // R7: pulse at zero count is ignored
  a_r7_zero_ignores_toggle: assert property (@(posedge clk) disable iff (rst)
    (toggle_i && freeze_i) |=> $stable(running_o));

endmodule

// File: rtl/bcd_down_counter.sv
module bcd_down_counter
  import cdt_pkg::*;
#(
  parameter int START_TENS  = 3,
  parameter int START_UNITS = 0
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  dec_en_i,
  output bcd2_t value_o,
  output logic  zero_o
);

  localparam bcd2_t INIT_V = '{tens: 4'(START_TENS), units: 4'(START_UNITS)};

  bcd2_t       value_q;
  logic        dec_fire;
  int unsigned value_bin;

  assign zero_o    = bcd2_is_zero(value_q);
  assign dec_fire  = dec_en_i && !zero_o;
  assign value_bin = bcd2_value(value_q);

  always_ff @(posedge clk) begin
    if (rst)           value_q <= INIT_V;
    else if (dec_fire) value_q <= bcd2_dec(value_q);
  end

  assign value_o = value_q;

  // R1 R10: reset loads the start value
  a_r1_reset_loads: assert property (@(posedge clk)
    rst |=> (value_q == INIT_V));

  // R2: a fired decrement lowers the value by one
  a_r2_step_one: assert property (@(posedge clk) disable iff (rst)
    dec_fire |=> (value_bin == $past(value_bin) - 1));

  // R3: no enable, no change
  a_r3_hold_without_enable: assert property (@(posedge clk) disable iff (rst)
    !dec_en_i |=> $stable(value_q));

  // R5: zero is sticky
  a_r5_zero_sticks: assert property (@(posedge clk) disable iff (rst)
    zero_o |=> zero_o);

  // R8: digits stay valid decimal
  a_r8_digits_valid: assert property (@(posedge clk) disable iff (rst)
    (value_q.units <= 4'd9) && (value_q.tens <= 4'(START_TENS)));

endmodule

// File: rtl/zero_led_bank.sv
module zero_led_bank #(
  parameter int LED_W = 16
) (
  input  logic             lit_i,
  output logic [LED_W-1:0] bank_o
);

  for (genvar i = 0; i < LED_W; i++) begin : g_led
    assign bank_o[i] = lit_i;
  end

endmodule

// File: rtl/pause_countdown_timer.sv
module pause_countdown_timer
  import cdt_pkg::*;
#(
  parameter int LED_W       = 16,
  parameter int START_TENS  = 3,
  parameter int START_UNITS = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_stop,
  input  logic             sec_tick,
  output logic [3:0]       tens_digit,
  output logic [3:0]       units_digit,
  output logic             run_led,
  output logic [LED_W-1:0] led_bank
);

  logic  running;
  logic  at_zero;
  logic  dec_en;
  bcd2_t count;

  assign dec_en = sec_tick && running;

  run_toggle_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .toggle_i  (start_stop),
    .freeze_i  (at_zero),
    .running_o (running)
  );

  bcd_down_counter #(
    .START_TENS  (START_TENS),
    .START_UNITS (START_UNITS)
  ) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .dec_en_i (dec_en),
    .value_o  (count),
    .zero_o   (at_zero)
  );

  zero_led_bank #(.LED_W(LED_W)) u_bank (
    .lit_i  (at_zero),
    .bank_o (led_bank)
  );

  assign tens_digit  = count.tens;
  assign units_digit = count.units;
  assign run_led     = running;

  // R6: bank all-on exactly at zero digits, else all-off
  a_r6_bank_matches_digits: assert property (@(posedge clk) disable iff (rst)
    ((tens_digit == 4'd0 && units_digit == 4'd0) ? (led_bank == '1) : (led_bank == '0)));

  // R9: a paused timer ignores a tick even if start arrives with it
  a_r9_pre_edge_state: assert property (@(posedge clk) disable iff (rst)
    (!run_led && sec_tick) |=> ($stable(tens_digit) && $stable(units_digit)));

endmodule

// File: tb/pause_countdown_timer_tb_top.sv
module pause_countdown_timer_tb_top;
  localparam int LED_W = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst, start_stop, sec_tick;
  logic [3:0]       tens_digit, units_digit;
  logic             run_led;
  logic [LED_W-1:0] led_bank;

  pause_countdown_timer #(.LED_W(LED_W)) dut_i (
    .clk(clk), .rst(rst), .start_stop(start_stop), .sec_tick(sec_tick),
    .tens_digit(tens_digit), .units_digit(units_digit),
    .run_led(run_led), .led_bank(led_bank)
  );

  int m_cnt;
  bit m_run;
  int tests = 0;
  int fails = 0;

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int cur_count();
    return int'(tens_digit) * 10 + int'(units_digit);
  endfunction

  // drive at falling edge, model at rising edge, compare at next falling edge
  task automatic step(bit r, bit tg, bit tk);
    rst = r; start_stop = tg; sec_tick = tk;
    @(posedge clk);
    if (r) begin
      m_cnt = 30; m_run = 0;
    end else begin
      bit nonzero;
      nonzero = (m_cnt > 0);
      if (tk && m_run && m_cnt > 0) m_cnt = m_cnt - 1;
      if (tg && nonzero) m_run = !m_run;
    end
    @(negedge clk);
    check(int'(tens_digit) == m_cnt / 10, "R8 tens", int'(tens_digit), m_cnt / 10);
    check(int'(units_digit) == m_cnt % 10, "R2 R8 units", int'(units_digit), m_cnt % 10);
    check(run_led == m_run, "R4 run_led", int'(run_led), int'(m_run));
    check(int'(led_bank) == ((m_cnt == 0) ? 32'hFFFF : 0), "R6 bank",
          int'(led_bank), (m_cnt == 0) ? 32'hFFFF : 0);
  endtask

  initial begin
    rst = 1'b1; start_stop = 1'b0; sec_tick = 1'b0;
    @(negedge clk);
    step(1, 0, 0);
    step(1, 0, 0);
    // R1
    check(cur_count() == 30 && !run_led && led_bank == '0, "R1 reset state", cur_count(), 30);

    // R3: ticks while paused do nothing
    for (int i = 0; i < 4; i++) step(0, 0, 1);
    check(cur_count() == 30, "R3 paused ticks", cur_count(), 30);

    step(0, 1, 0);                       // start
    check(run_led == 1'b1, "R4 start", int'(run_led), 1);
    step(0, 0, 1);
    check(cur_count() == 29, "R2 first tick", cur_count(), 29);
    step(0, 0, 0);
    check(cur_count() == 29, "R3 no tick", cur_count(), 29);
    step(0, 0, 1);
    step(0, 0, 1);

    step(0, 1, 0);                       // pause
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    check(cur_count() == 27, "R3 paused hold", cur_count(), 27);

    // R9: start with tick while paused -> no decrement
    step(0, 1, 1);
    check(cur_count() == 27 && run_led, "R9 start+tick", cur_count(), 27);
    // R9: stop with tick while running -> decrement
    step(0, 1, 1);
    check(cur_count() == 26 && !run_led, "R9 stop+tick", cur_count(), 26);

    step(0, 1, 0);                       // resume
    while (m_cnt > 0) begin
      step(0, 0, 1);
      step(0, 0, 0);
    end
    check(cur_count() == 0 && led_bank == '1, "R6 zero lights bank", cur_count(), 0);

    // R5: more ticks at zero, no wrap
    for (int i = 0; i < 3; i++) step(0, 0, 1);
    check(cur_count() == 0 && led_bank == '1, "R5 holds zero", cur_count(), 0);

    // R7: start/stop at zero ignored
    step(0, 1, 0);
    check(run_led == 1'b1, "R7 toggle at zero", int'(run_led), 1);
    step(0, 1, 1);
    check(run_led == 1'b1 && cur_count() == 0, "R7 toggle+tick at zero", int'(run_led), 1);

    // R10: reset wins over pulse and tick, leaves zero
    step(1, 1, 1);
    check(cur_count() == 30 && !run_led && led_bank == '0, "R10 reset from zero", cur_count(), 30);
    step(0, 1, 0);
    step(0, 0, 1);
    check(cur_count() == 29, "R2 after reset", cur_count(), 29);
    // R10: reset during running
    step(1, 0, 1);
    check(cur_count() == 30 && !run_led, "R10 reset while running", cur_count(), 30);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 5000, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule